// File: doc/BRIEF.md
# Ring Oscillator Aging Monitor Controller

This controller supervises a set of wear-out sensors. Each sensor is a small ring oscillator whose slowest stage copies the most heavily stressed transistor of a protected adder. In normal operation the controller keeps every ring stopped and feeds each sensor a stress waveform. That waveform is the system clock gated by the carry-in of that sensor's adder, so the replica ages at the same rate as the transistor it copies. A single oscillation counter is shared by all sensors. Each accepted check request gives the counter to the next sensor in round-robin order. The controller enables that ring and waits for a reference tick that does not age. It then counts ring rising edges until the following tick.

The first measurement of a sensor after reset is taken while the sensor is still fresh. That count becomes its calibration value. The pass threshold is stored as the count minus the allowed slowdown fraction `(count*DER_NUM)>>DER_SHIFT`. Software may instead load a threshold through a valid/ready port. That port is back-pressured (`thr_ready` low) for the whole time a check is in flight. A source holds `thr_valid`, `thr_sel` and `thr_data` until the cycle in which `thr_ready` is high. Every later check compares its count with the stored threshold. A shortfall raises a fail flag for that sensor, and the flag stays set until reset.

Top module: `aging_monitor_ctrl`

## Requirements
- R1: After reset, `ring_en`, `fail`, `done` and `done_flag` are all 0, and `thr_ready` is 1.
- R2: For every sensor whose `ring_en` bit is 0, `stress` equals `clk & carry_in` for that bit. A sensor whose ring is enabled receives `stress` = 0.
- R3: At most one `ring_en` bit is high at any time. That bit belongs to the sensor under check, and it stays high from the cycle after `chk_req` is accepted until `done` rises.
- R4: The reported count is the number of `ring_in` rising edges of the selected sensor between the first `ref_tick` after acceptance and the next `ref_tick`. Edges before the window, and edges on other sensors, are not counted.
- R5: The count saturates at 2^CNT_W-1 and does not wrap.
- R6: The first check of a sensor after reset is a calibration check, unless a threshold was written to that sensor first. It stores `count - ((count*DER_NUM) >> DER_SHIFT)` as the threshold and never reports a failure.
- R7: On a later check, a count strictly below the threshold sets `done_flag` and `fail[i]`. A count equal to the threshold passes.
- R8: A set `fail[i]` bit remains 1 until reset.
- R9: Checks visit sensors 0, 1, …, NSENS-1, 0, … in order, one sensor per accepted request.
- R10: `done` is a one-cycle pulse in the cycle after the closing `ref_tick` is sampled. In that cycle `done_sensor`, `done_count` and `done_flag` describe the finished check, and all rings are off.
- R11: `thr_ready` is 1 only while no check is in flight. An accepted write stores `thr_data` as the threshold of sensor `thr_sel` and marks that sensor as calibrated.
- R12: `chk_req` pulses while a check is in flight are ignored. They start no extra check and do not advance the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carry_in | input | NSENS | Carry-in of each protected adder |
| ring_in | input | NSENS | Ring outputs, asynchronous to clk |
| ref_tick | input | 1 | Non-aging reference tick that opens and closes the window |
| chk_req | input | 1 | Start-check request pulse |
| thr_valid | input | 1 | Threshold write valid |
| thr_ready | output | 1 | Threshold write ready (controller idle) |
| thr_sel | input | IDX_W | Sensor index of the threshold write |
| thr_data | input | CNT_W | Threshold value |
| ring_en | output | NSENS | Ring enable, one-hot or zero |
| stress | output | NSENS | Stress drive to each sensor |
| fail | output | NSENS | Sticky per-sensor unsafe flags |
| done | output | 1 | End-of-check pulse |
| done_sensor | output | IDX_W | Sensor that just finished |
| done_count | output | CNT_W | Edge count of that check |
| done_flag | output | 1 | This check failed |

## Verification
Two events can fall in the same cycle: a threshold write and the acceptance of a check request. Both are sampled while the controller is idle. The bench drives `thr_valid` and `chk_req` together, aimed at a sensor that is already calibrated. The written threshold is set so that it fails a count the old threshold would have passed. The check is judged correct only if `done_flag` follows the newly written value. The bench also injects check requests inside a running window and noise edges on the other rings. It then confirms that the round-robin order and the counts do not change.

// File: rtl/aging_mon_pkg.sv
package aging_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_WIN  = 2'd2
  } mon_state_t;
endpackage

// File: rtl/aging_edge_sync.sv
module aging_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/aging_sat_counter.sv
module aging_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_comb begin
    if (clr_i)                     cnt_nxt_o = '0;
    else if (inc_i && cnt_q != MAXV) cnt_nxt_o = cnt_q + 1'b1;
    else                           cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr_i) |=> (cnt_q == MAXV));
endmodule

// File: rtl/aging_thr_bank.sv
module aging_thr_bank #(
  parameter int NSENS     = 4,
  parameter int W         = 8,
  parameter int DER_NUM   = 1,
  parameter int DER_SHIFT = 3,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [IDX_W-1:0] eval_idx_i,
  input  logic [W-1:0]     eval_cnt_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_val_i,
  output logic             verdict_o,
  output logic [NSENS-1:0] fail_o
);
  localparam int NUM_W = $clog2(DER_NUM + 1) + 1;
  localparam int PW    = W + NUM_W;

  logic [W-1:0]     thr_q [NSENS];
  logic [NSENS-1:0] cal_q;
  logic [NSENS-1:0] fail_q;
  logic [PW-1:0]    prod;
  logic [W-1:0]     derated;
  logic [W-1:0]     cur_thr;
  logic             cur_cal;

  assign prod    = PW'(eval_cnt_i) * PW'(DER_NUM);
  assign derated = eval_cnt_i - W'(prod >> DER_SHIFT);

  always_comb begin
    cur_thr = '0;
    cur_cal = 1'b0;
    for (int i = 0; i < NSENS; i++) begin
      if (eval_idx_i == IDX_W'(i)) begin
        cur_thr = thr_q[i];
        cur_cal = cal_q[i];
      end
    end
  end

  assign verdict_o = cur_cal && (eval_cnt_i < cur_thr);

  for (genvar g = 0; g < NSENS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[g]  <= '0;
        cal_q[g]  <= 1'b0;
        fail_q[g] <= 1'b0;
      end else begin
        if (wr_i && wr_idx_i == IDX_W'(g)) begin
          thr_q[g] <= wr_val_i;
          cal_q[g] <= 1'b1;
        end else if (eval_i && eval_idx_i == IDX_W'(g) && !cal_q[g]) begin
          thr_q[g] <= derated;
          cal_q[g] <= 1'b1;
        end
        if (eval_i && eval_idx_i == IDX_W'(g) && verdict_o)
          fail_q[g] <= 1'b1;
      end
    end

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q[g] |=> fail_q[g]);
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/aging_monitor_ctrl.sv
module aging_monitor_ctrl
  import aging_mon_pkg::*;
#(
  parameter int NSENS     = 4,
  parameter int CNT_W     = 8,
  parameter int DER_NUM   = 1,
  parameter int DER_SHIFT = 3,
  localparam int IDX_W    = (NSENS > 1) ? $clog2(NSENS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSENS-1:0] carry_in,
  input  logic [NSENS-1:0] ring_in,
  input  logic             ref_tick,
  input  logic             chk_req,
  input  logic             thr_valid,
  output logic             thr_ready,
  input  logic [IDX_W-1:0] thr_sel,
  input  logic [CNT_W-1:0] thr_data,
  output logic [NSENS-1:0] ring_en,
  output logic [NSENS-1:0] stress,
  output logic [NSENS-1:0] fail,
  output logic             done,
  output logic [IDX_W-1:0] done_sensor,
  output logic [CNT_W-1:0] done_count,
  output logic             done_flag
);
  mon_state_t       state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [NSENS-1:0] rise;
  logic             rise_sel;
  logic             accept, closing;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             verdict;
  logic             done_q, flag_q;
  logic [IDX_W-1:0] dsens_q;
  logic [CNT_W-1:0] dcnt_q;

  for (genvar g = 0; g < NSENS; g++) begin : g_sens
    aging_edge_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ring_in[g]),
      .rise_o  (rise[g])
    );
    assign ring_en[g] = (state_q != ST_IDLE) && (ptr_q == IDX_W'(g));
    assign stress[g]  = clk & carry_in[g] & ~ring_en[g];
  end

  always_comb begin
    rise_sel = 1'b0;
    for (int i = 0; i < NSENS; i++)
      if (ptr_q == IDX_W'(i)) rise_sel = rise[i];
  end

  assign accept    = (state_q == ST_IDLE) && chk_req;
  assign closing   = (state_q == ST_WIN) && ref_tick;
  assign thr_ready = (state_q == ST_IDLE);

  aging_sat_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (accept),
    .inc_i     ((state_q == ST_WIN) && rise_sel),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  aging_thr_bank #(
    .NSENS(NSENS), .W(CNT_W), .DER_NUM(DER_NUM),
    .DER_SHIFT(DER_SHIFT), .IDX_W(IDX_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (closing),
    .eval_idx_i (ptr_q),
    .eval_cnt_i (cnt_nxt),
    .wr_i       (thr_valid && thr_ready),
    .wr_idx_i   (thr_sel),
    .wr_val_i   (thr_data),
    .verdict_o  (verdict),
    .fail_o     (fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
      dsens_q <= '0;
      dcnt_q  <= '0;
    end else begin
      done_q <= closing;
      unique case (state_q)
        ST_IDLE: if (chk_req) state_q <= ST_ARM;
        ST_ARM:  if (ref_tick) state_q <= ST_WIN;
        ST_WIN:  if (ref_tick) begin
          state_q <= ST_IDLE;
          ptr_q   <= (ptr_q == IDX_W'(NSENS - 1)) ? '0 : ptr_q + 1'b1;
          flag_q  <= verdict;
          dsens_q <= ptr_q;
          dcnt_q  <= cnt_nxt;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done        = done_q;
  assign done_flag   = flag_q;
  assign done_sensor = dsens_q;
  assign done_count  = dcnt_q;

  assert_one_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring_en));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_rings_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ring_en == '0));
  assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM) |=> (cnt == '0));
endmodule

// File: tb/tb_aging_monitor_ctrl.sv
module tb_aging_monitor_ctrl;
  localparam int NS = 4, CW = 8, DN = 1, DS = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] carry_in = '0, ring_in = '0;
  logic ref_tick = 0, chk_req = 0, thr_valid = 0;
  logic [IW-1:0] thr_sel = '0;
  logic [CW-1:0] thr_data = '0;
  logic thr_ready, done, done_flag;
  logic [NS-1:0] ring_en, stress, fail;
  logic [IW-1:0] done_sensor;
  logic [CW-1:0] done_count;

  aging_monitor_ctrl #(.NSENS(NS), .CNT_W(CW), .DER_NUM(DN), .DER_SHIFT(DS)) dut (
    .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .ring_in(ring_in),
    .ref_tick(ref_tick), .chk_req(chk_req), .thr_valid(thr_valid),
    .thr_ready(thr_ready), .thr_sel(thr_sel), .thr_data(thr_data),
    .ring_en(ring_en), .stress(stress), .fail(fail), .done(done),
    .done_sensor(done_sensor), .done_count(done_count), .done_flag(done_flag));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int exp_ptr = 0;
  int m_thr [NS];
  bit m_cal [NS];
  bit [NS-1:0] m_fail = '0;

  always @(posedge clk) cycles++;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int derate(int c);
    return c - ((c * DN) >> DS);
  endfunction

  function automatic int satv(int k);
    return (k > 255) ? 255 : k;
  endfunction

  task automatic pulses(logic [NS-1:0] mask, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) ring_in = mask;
      repeat (3) @(negedge clk);
      ring_in = '0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic wr_thr(int s, int v);
    @(negedge clk);
    chk(thr_ready == 1'b1, "R11 ready when idle", thr_ready, 1);
    thr_valid = 1; thr_sel = IW'(s); thr_data = CW'(v);
    @(negedge clk) thr_valid = 0;
    m_thr[s] = v; m_cal[s] = 1;
  endtask

  task automatic stress_probe(logic [NS-1:0] cin);
    carry_in = cin;
    @(posedge clk) #1;
    chk(stress == (cin & ~ring_en), "R2 stress high phase", stress, cin & ~ring_en);
    @(negedge clk) #1;
    chk(stress == '0, "R2 stress low phase", stress, 0);
  endtask

  task automatic do_check(int k, int pre, bit wr_same, int wv, bit busy_req);
    int s, kc;
    bit verdict;
    logic [NS-1:0] tmask, noise;
    s = exp_ptr;
    tmask = NS'(1) << s;
    noise = ~tmask;
    @(negedge clk) chk_req = 1;
    if (wr_same) begin thr_valid = 1; thr_sel = IW'(s); thr_data = CW'(wv); end
    @(negedge clk) chk_req = 0; thr_valid = 0;
    if (wr_same) begin m_thr[s] = wv; m_cal[s] = 1; end
    chk(ring_en == tmask, "R3 ring enable on accept", ring_en, tmask);
    chk(thr_ready == 1'b0, "R11 back-pressure in check", thr_ready, 0);
    pulses(tmask, pre);
    pulses(noise, 1);
    repeat (3) @(negedge clk);
    ref_tick = 1;
    @(negedge clk) ref_tick = 0;
    repeat (3) @(negedge clk);
    pulses(noise, 2);
    if (busy_req) begin chk_req = 1; @(negedge clk) chk_req = 0; end
    pulses(tmask, k);
    repeat (4) @(negedge clk);
    chk(ring_en == tmask, "R3 ring enable held", ring_en, tmask);
    chk(done == 1'b0, "R10 no early done", done, 0);
    ref_tick = 1;
    @(negedge clk) ref_tick = 0;
    kc = satv(k);
    verdict = m_cal[s] && (kc < m_thr[s]);
    if (!m_cal[s]) begin m_thr[s] = derate(kc); m_cal[s] = 1; end
    m_fail[s] = m_fail[s] | verdict;
    chk(done == 1'b1, "R10 done pulse", done, 1);
    chk(done_sensor == IW'(s), "R9 round-robin sensor", done_sensor, s);
    chk(done_count == CW'(kc), "R4/R5 count", done_count, kc);
    chk(done_flag == verdict, "R6/R7 verdict", done_flag, verdict);
    chk(fail == m_fail, "R8 sticky fail vector", fail, m_fail);
    chk(ring_en == '0, "R10 rings off at done", ring_en, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(ring_en == '0, "R12 no extra check", ring_en, 0);
    exp_ptr = (exp_ptr + 1) % NS;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_thr[i] = 0; m_cal[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ring_en == '0, "R1 reset ring_en", ring_en, 0);
    chk(fail == '0, "R1 reset fail", fail, 0);
    chk(done == 1'b0 && done_flag == 1'b0, "R1 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(thr_ready == 1'b1, "R1 ready after reset", thr_ready, 1);
    stress_probe(4'b1011);
    chk_req = 0;
    ref_tick = 1; @(negedge clk) ref_tick = 0;
    chk(ring_en == '0, "R3 tick alone starts nothing", ring_en, 0);

    wr_thr(3, 10);
    do_check(7, 2, 0, 0, 0);    // R6 s0 calibrates to 7
    do_check(40, 0, 0, 0, 1);   // R6 s1 -> 35, R12 busy request
    do_check(300, 1, 0, 0, 0);  // R5 saturate, s2 -> 224
    do_check(9, 0, 0, 0, 0);    // R11 written 10, 9 fails
    do_check(6, 0, 0, 0, 0);    // R7 one-count shortfall
    do_check(35, 1, 0, 0, 0);   // R7 equal passes
    do_check(224, 0, 0, 0, 0);  // R7 equal passes
    do_check(20, 0, 0, 0, 0);   // R8 s3 stays failed
    do_check(7, 0, 0, 0, 0);    // R8 s0 stays failed
    do_check(45, 0, 1, 50, 0);  // R11 write with accept, R7 fails vs 50
    do_check(223, 0, 0, 0, 0);  // R7 s2 below 224

    for (int r = 0; r < 14; r++) begin
      int k, pre;
      bit ws;
      k = $urandom_range(60, 0);
      pre = $urandom_range(2, 0);
      ws = ($urandom_range(3, 0) == 0);
      stress_probe(NS'($urandom));
      do_check(k, pre, ws, $urandom_range(40, 5), ($urandom_range(1, 0) == 1));
    end

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule